// File: doc/BRIEF.md
# Programmable Color Component Extractor

This block sits in the pixel path of a scan-out display controller, between the frame-buffer fetch and the video output. Each cycle it takes one raw pixel word with two per-pixel qualifiers. One qualifier says whether the pixel lies in the visible area. The other says whether the fetch ran dry for this pixel. From that word the block forms 8-bit red, green and blue values.

How each color is formed is set by software at run time. Every channel has its own selection word with three fields: the lowest source bit, the number of bits to take, and a fallback level. A separate format word gives the pixel size, from one to four bytes. A channel shows its fallback level in three cases: it takes no bits, the pixel is outside the visible area, or the fetch underran. Each channel has its own fallback, so an underrun can be made to show as a chosen color, for example pure red.

Settings written by software are held in a staging copy. They reach the data path only when a new frame starts. The output is one register stage, and the timing sideband travels through the same stage.

Top module: `pixel_color_extract`

## Requirements
- R1: A selection word uses bits [4:0] for the lowest source bit, bits [11:8] for the bit count and bits [23:16] for the 8-bit fallback level. Write address 0 selects red, 1 selects green, 2 selects blue and 3 selects the format word.
- R2: A channel whose bit count is zero outputs its fallback level and ignores the pixel.
- R3: When the visible-area flag is low, all three channels output their own fallback levels.
- R4: When the underrun flag is high, all three channels output their own fallback levels, even inside the visible area.
- R5: Format bits [4:3] hold the bytes per pixel minus one. Pixel bits at or above 8 × (bytes per pixel) read as zero before extraction.
- R6: The extracted field is left-aligned in the 8-bit output, and the unused low bits are zero.
- R7: A bit count above 8 acts as 8. Source bits above the top of the pixel word read as zero.
- R8: Color outputs appear one clock after the pixel is presented. The valid, hsync, vsync and data-enable inputs come out in the same cycle as the color they belong to.
- R9: A written setting has no effect until a rising edge of the vsync input. The pixel presented together with that edge still uses the previous settings, and the next pixel uses the new ones.
- R10: Reset clears all selection and format settings and the outputs. Until new settings are loaded, every channel then outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting select: 0 red, 1 green, 2 blue, 3 format |
| cfg_wdata | input | 32 | Setting write data |
| pix_valid | input | 1 | Pixel word valid |
| pix_data | input | 32 | Raw pixel word from the frame buffer |
| pix_active | input | 1 | Pixel lies in the visible area |
| pix_underrun | input | 1 | Fetch underran for this pixel |
| pix_hsync | input | 1 | Horizontal sync, passed through |
| pix_vsync | input | 1 | Vertical sync, passed through; its rising edge applies settings |
| pix_de | input | 1 | Data enable, passed through |
| out_valid | output | 1 | Delayed pixel valid |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data enable |

## Verification
Every color result and every sideband copy is due exactly one clock after its inputs are captured. The bench drives stimulus on the falling edge, lets one rising edge pass, and samples on the following falling edge. A setting write is followed by a vsync pulse whose rise is taken at the next rising edge. The bench therefore presents pixels only after the pulse has fully ended. It also checks that a pixel sent after a write but before any vsync still shows the old result.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int PIX_W  = 32;
  localparam int CH_W   = 8;
  localparam int NUM_CH = 3;
  localparam int OFF_W  = $clog2(PIX_W);
  localparam int LEN_W  = 4;
  localparam int BPP_W  = 2;
  localparam int CFG_W  = 32;

  localparam int OFF_LSB  = 0;
  localparam int LEN_LSB  = 8;
  localparam int DFLT_LSB = 16;
  localparam int BPP_LSB  = 3;

  localparam logic [1:0] ADDR_FMT = 2'd3;

  typedef struct packed {
    logic [CH_W-1:0]  dflt;
    logic [LEN_W-1:0] len;
    logic [OFF_W-1:0] off;
  } chan_sel_t;

  function automatic chan_sel_t decode_sel(input logic [CFG_W-1:0] w);
    chan_sel_t s;
    s.dflt = w[DFLT_LSB +: CH_W];
    s.len  = w[LEN_LSB +: LEN_W];
    s.off  = w[OFF_LSB +: OFF_W];
    return s;
  endfunction
endpackage

// File: rtl/pce_cfg_bank.sv
module pce_cfg_bank
  import pce_pkg::*;
#(
  parameter int N_CH = NUM_CH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [1:0]             addr,
  input  logic [CFG_W-1:0]       wdata,
  input  logic                   apply,
  output chan_sel_t              act_sel [N_CH],
  output logic [BPP_W-1:0]       act_bpp
);
  chan_sel_t        stg_sel [N_CH];
  logic [BPP_W-1:0] stg_bpp;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_sel[c] <= '0;
        act_sel[c] <= '0;
      end else begin
        if (we && addr == 2'(c)) stg_sel[c] <= decode_sel(wdata);
        if (apply) act_sel[c] <= stg_sel[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_bpp <= '0;
      act_bpp <= '0;
    end else begin
      if (we && addr == ADDR_FMT) stg_bpp <= wdata[BPP_LSB +: BPP_W];
      if (apply) act_bpp <= stg_bpp;
    end
  end
endmodule

// File: rtl/pce_byte_mask.sv
module pce_byte_mask
  import pce_pkg::*;
(
  input  logic [PIX_W-1:0] raw,
  input  logic [BPP_W-1:0] bpp_m1,
  output logic [PIX_W-1:0] masked
);
  localparam int NBYTES = PIX_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic keep;
    assign keep = (b <= int'(bpp_m1));
    assign masked[b*8 +: 8] = keep ? raw[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pce_chan_extract.sv
module pce_chan_extract
  import pce_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  chan_sel_t        sel,
  input  logic             force_dflt,
  output logic [CH_W-1:0]  color
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(CH_W);

  logic [PIX_W-1:0] shifted;
  logic [LEN_W-1:0] cnt;
  logic [CH_W:0]    fmask;
  logic [CH_W-1:0]  field;

  always_comb begin
    shifted = pix >> sel.off;
    cnt     = (sel.len > MAX_LEN) ? MAX_LEN : sel.len;
    fmask   = ((CH_W+1)'(1) << cnt) - (CH_W+1)'(1);
    field   = shifted[CH_W-1:0] & fmask[CH_W-1:0];
    if (force_dflt || cnt == '0) color = sel.dflt;
    else                         color = field << (MAX_LEN - cnt);
  end
endmodule

// File: rtl/pixel_color_extract.sv
module pixel_color_extract
  import pce_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             pix_valid,
  input  logic [31:0]      pix_data,
  input  logic             pix_active,
  input  logic             pix_underrun,
  input  logic             pix_hsync,
  input  logic             pix_vsync,
  input  logic             pix_de,
  output logic             out_valid,
  output logic [7:0]       out_red,
  output logic [7:0]       out_green,
  output logic [7:0]       out_blue,
  output logic             out_hsync,
  output logic             out_vsync,
  output logic             out_de
);
  chan_sel_t        act_sel [NUM_CH];
  logic [BPP_W-1:0] act_bpp;
  logic             vs_q;
  logic             vs_rise;
  logic [PIX_W-1:0] pix_m;
  logic             blank;
  logic [CH_W-1:0]  color [NUM_CH];
  logic [NUM_CH*CH_W-1:0]  act_dflt_flat;
  logic [NUM_CH*LEN_W-1:0] act_len_flat;

  assign vs_rise = pix_vsync && !vs_q;
  assign blank   = !pix_active || pix_underrun;

  always_ff @(posedge clk) begin
    if (rst) vs_q <= 1'b0;
    else     vs_q <= pix_vsync;
  end

  pce_cfg_bank #(.N_CH(NUM_CH)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .apply   (vs_rise),
    .act_sel (act_sel),
    .act_bpp (act_bpp)
  );

  pce_byte_mask u_mask (
    .raw    (pix_data),
    .bpp_m1 (act_bpp),
    .masked (pix_m)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pce_chan_extract u_ext (
      .pix        (pix_m),
      .sel        (act_sel[c]),
      .force_dflt (blank),
      .color      (color[c])
    );
    assign act_dflt_flat[c*CH_W +: CH_W]   = act_sel[c].dflt;
    assign act_len_flat[c*LEN_W +: LEN_W]  = act_sel[c].len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_red   <= '0;
      out_green <= '0;
      out_blue  <= '0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      out_de    <= 1'b0;
    end else begin
      out_valid <= pix_valid;
      out_red   <= color[0];
      out_green <= color[1];
      out_blue  <= color[2];
      out_hsync <= pix_hsync;
      out_vsync <= pix_vsync;
      out_de    <= pix_de;
    end
  end
endmodule

// File: rtl/pixel_color_extract_chk.sv
module pixel_color_extract_chk (
  input logic        clk,
  input logic        rst,
  input logic        pix_valid,
  input logic        pix_active,
  input logic        pix_underrun,
  input logic        pix_hsync,
  input logic        pix_vsync,
  input logic        pix_de,
  input logic        vs_rise,
  input logic [23:0] act_dflt,
  input logic [11:0] act_len,
  input logic        out_valid,
  input logic [7:0]  out_red,
  input logic [7:0]  out_green,
  input logic [7:0]  out_blue,
  input logic        out_hsync,
  input logic        out_vsync,
  input logic        out_de
);
  // R8: sideband leaves one clock after entry
  a_r8_sideband_align: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(pix_valid) && out_hsync == $past(pix_hsync) &&
                     out_vsync == $past(pix_vsync) && out_de == $past(pix_de)));

  // R3 / R4: blanked pixel shows each channel's fallback level
  a_r3_r4_blank_default: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!pix_active || pix_underrun)) |->
      ({out_blue, out_green, out_red} == $past(act_dflt)));

  // R2: zero bit count on red selects red fallback
  a_r2_zero_len_red: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(act_len[3:0]) == 4'd0) |-> out_red == $past(act_dflt[7:0]));

  // R9: live settings change only after a vsync rise
  a_r9_hold_until_vsync: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(vs_rise)) |-> ($stable(act_dflt) && $stable(act_len)));
endmodule

bind pixel_color_extract pixel_color_extract_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .pix_valid    (pix_valid),
  .pix_active   (pix_active),
  .pix_underrun (pix_underrun),
  .pix_hsync    (pix_hsync),
  .pix_vsync    (pix_vsync),
  .pix_de       (pix_de),
  .vs_rise      (vs_rise),
  .act_dflt     (act_dflt_flat),
  .act_len      (act_len_flat),
  .out_valid    (out_valid),
  .out_red      (out_red),
  .out_green    (out_green),
  .out_blue     (out_blue),
  .out_hsync    (out_hsync),
  .out_vsync    (out_vsync),
  .out_de       (out_de)
);

// File: tb/tb_pixel_color_extract.sv
module tb_pixel_color_extract;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic        pix_active = 1'b0;
  logic        pix_underrun = 1'b0;
  logic        pix_hsync = 1'b0;
  logic        pix_vsync = 1'b0;
  logic        pix_de = 1'b0;
  logic        out_valid, out_hsync, out_vsync, out_de;
  logic [7:0]  out_red, out_green, out_blue;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pixel_color_extract dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_active(pix_active),
    .pix_underrun(pix_underrun), .pix_hsync(pix_hsync), .pix_vsync(pix_vsync),
    .pix_de(pix_de), .out_valid(out_valid), .out_red(out_red), .out_green(out_green),
    .out_blue(out_blue), .out_hsync(out_hsync), .out_vsync(out_vsync), .out_de(out_de)
  );

  // entry: red sel, green sel, blue sel, format, pixel, active, underrun, expected RGB
  localparam int NV = 9;
  localparam logic [185:0] VEC [NV] = '{
    {32'h00000810, 32'h00000808, 32'h00000800, 32'h18, 32'h00123456, 1'b1, 1'b0, 24'h123456}, // R1 R6 888
    {32'h0000050B, 32'h00000605, 32'h00000500, 32'h08, 32'hFFFFF800, 1'b1, 1'b0, 24'hF80000}, // R5 R6 565
    {32'h00000804, 32'h007F0000, 32'h00000C00, 32'h00, 32'h0000FFFF, 1'b1, 1'b0, 24'h0F7FFF}, // R2 R5 R7
    {32'h00FF0810, 32'h00110808, 32'h00220800, 32'h18, 32'h00ABCDEF, 1'b0, 1'b0, 24'hFF1122}, // R3
    {32'h00FF0810, 32'h00110808, 32'h00220800, 32'h18, 32'h00ABCDEF, 1'b1, 1'b1, 24'hFF1122}, // R4
    {32'h00FF0810, 32'h00110808, 32'h00220800, 32'h18, 32'h00ABCDEF, 1'b1, 1'b0, 24'hABCDEF}, // R1
    {32'h0000081C, 32'h0000021E, 32'h0000011F, 32'h18, 32'hA0000000, 1'b1, 1'b0, 24'h0A8080}, // R7 R6
    {32'h00000300, 32'h00000401, 32'h00000802, 32'h00, 32'h00000105, 1'b1, 1'b0, 24'hA02001}, // R6 R5
    {32'h00000810, 32'h00000818, 32'h00000F00, 32'h10, 32'hFF800000, 1'b1, 1'b0, 24'h800000}  // R5 R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    pix_vsync = 1'b1; pix_valid = 1'b0;
    @(negedge clk);
    pix_vsync = 1'b0;
  endtask

  // drive at falling edge, capture at next rising edge, sample at following falling edge
  task automatic pixel(input logic [31:0] d, input logic act, input logic und);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = d; pix_active = act; pix_underrun = und;
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R10: outputs clear in reset
    check("R10 reset outputs", {out_valid, out_red, out_green, out_blue}, 32'h0);
    @(negedge clk); rst = 1'b0;

    // R10: cleared settings give zero even for an active pixel
    pixel(32'hFFFFFFFF, 1'b1, 1'b0);
    check("R10 cleared config color", {8'h0, out_red, out_green, out_blue}, 32'h0);

    // table walk: R1..R7
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i][185:154]);
      wr(2'd1, VEC[i][153:122]);
      wr(2'd2, VEC[i][121:90]);
      wr(2'd3, VEC[i][89:58]);
      frame_pulse();
      pixel(VEC[i][57:26], VEC[i][25], VEC[i][24]);
      check($sformatf("R1-table vec%0d", i), {8'h0, out_red, out_green, out_blue},
            {8'h0, VEC[i][23:0]});
    end

    // R9: write without vsync keeps old settings (888 from last loaded? reload 888)
    wr(2'd0, 32'h00000810); wr(2'd1, 32'h00000808); wr(2'd2, 32'h00000800); wr(2'd3, 32'h18);
    frame_pulse();
    wr(2'd0, 32'h00000800);
    pixel(32'h00123456, 1'b1, 1'b0);
    check("R9 no apply before vsync", {24'h0, out_red}, 32'h12);
    frame_pulse();
    pixel(32'h00123456, 1'b1, 1'b0);
    check("R9 applied after vsync", {24'h0, out_red}, 32'h56);

    // R9: pixel presented with the vsync rise uses previous settings
    wr(2'd0, 32'h00000810);
    @(negedge clk);
    pix_vsync = 1'b1; pix_valid = 1'b1; pix_data = 32'h00123456; pix_active = 1'b1;
    @(negedge clk);
    check("R9 rise pixel old config", {24'h0, out_red}, 32'h56);
    pix_vsync = 1'b0;
    @(negedge clk);
    check("R9 next pixel new config", {24'h0, out_red}, 32'h12);
    pix_valid = 1'b0;

    // R8: sideband alignment one clock later
    @(negedge clk);
    pix_valid = 1'b1; pix_hsync = 1'b1; pix_de = 1'b0; pix_data = 32'h00AABBCC;
    @(negedge clk);
    check("R8 sideband cycle1", {28'h0, out_valid, out_hsync, out_vsync, out_de}, 32'b1100);
    check("R8 color cycle1", {8'h0, out_red, out_green, out_blue}, 32'h00AABBCC);
    pix_valid = 1'b0; pix_hsync = 1'b0; pix_de = 1'b1; pix_data = 32'h00112233;
    @(negedge clk);
    check("R8 sideband cycle2", {28'h0, out_valid, out_hsync, out_vsync, out_de}, 32'b0001);
    check("R8 color cycle2", {8'h0, out_red, out_green, out_blue}, 32'h00112233);
    pix_de = 1'b0;

    // R10: reset mid-run clears live settings
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    pixel(32'h00FFFFFF, 1'b1, 1'b0);
    check("R10 reset clears live config", {8'h0, out_red, out_green, out_blue}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule